// File: doc/BRIEF.md
# Version-Tagged Branch Target Table

This block is a direct-mapped table of branch targets that a fetch unit consults by program counter. Each row stores a valid flag, the upper PC bits as an address tag, the predicted target, and the domain version that was current when the row was written. A single global version register advances by one whenever the domain-switch pulse is seen. A row whose stored version differs from the current one no longer hits. Every row written under an earlier domain therefore becomes unusable in one cycle, whatever the table depth, and no row storage is rewritten.

The version is four bits wide, so after sixteen switches old values come round again. When the version steps from its highest value back to zero, the block walks the table one row per cycle and clears each valid flag. It reports `busy` while it does so. During that walk every lookup misses and updates are refused.

Lookups are a plain query: `lk_valid` and `lk_pc` in, `lk_hit` and `lk_target` back in the same cycle, and every lookup is accepted. Updates form a valid/ready stream. A write takes place on a cycle where both `up_valid` and `up_ready` are high. While `up_ready` is low, an offered update is discarded and is not held for later, so the producer must keep offering it until it is accepted. The producer may raise or drop `up_valid` at any time.

Top module: `vtbt_table`

## Requirements
- R1: After reset, every row is invalid, the version is zero, `busy` is low and `up_ready` is high, so every lookup misses.
- R2: Each cycle with `dom_switch` high advances the 4-bit version by exactly one, modulo 16.
- R3: After a domain switch, every row written before that switch misses on lookup from the next cycle on, without any row being cleared.
- R4: A lookup hits only when `lk_valid` is high, `busy` is low, the row selected by PC bits [IDX_W+1:2] is valid, its tag equals PC bits [PC_W-1:IDX_W+2], and its version equals the current version; on a hit, `lk_target` is that row's target.
- R5: An update accepted on a clock edge (`up_valid` and `up_ready` high) stores the valid flag, tag, target and current version in that one edge, so a lookup of the same PC in the next cycle hits with the new target and a different PC that shares the index then misses.
- R6: An update accepted in the same cycle as a domain switch is stored with the new version and hits after the switch.
- R7: A switch that takes the version from 15 to 0 starts a sweep, and `busy` is high for exactly DEPTH cycles starting in the next cycle.
- R8: Once the sweep ends, rows written before the wrap miss, including rows whose stored version matches a version value that is reached again later.
- R9: While `busy` is high, `lk_hit` is low and `up_ready` is low, and any update offered in that time is dropped.
- R10: `up_ready` is low in any cycle where `dom_switch` is high and the version is 15.
- R11: With `lk_valid` low, `lk_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_pc | input | PC_W | Lookup program counter |
| lk_hit | output | 1 | Lookup found a live matching row |
| lk_target | output | TGT_W | Stored target of the selected row |
| up_valid | input | 1 | Update offered |
| up_ready | output | 1 | Update will be taken this cycle |
| up_pc | input | PC_W | Branch PC to record |
| up_target | input | TGT_W | Target to record |
| dom_switch | input | 1 | One-cycle pulse per security-domain switch |
| busy | output | 1 | Wrap sweep in progress |

## Verification
The checker assumes that sixteen domain switches never occur inside one sweep. If they did, a second wrap would restart the walk and `busy` would stay high for longer than DEPTH cycles. The checker also assumes that `dom_switch` is a pulse whose high cycles each mean one switch. The stimulus gives at most one switch per action and issues all switch pulses while `busy` is low, so the fixed busy length and the miss after a switch can be checked. The bench offers updates during the sweep only to show that they are dropped.

// File: rtl/vtbt_pkg.sv
package vtbt_pkg;
  localparam int VER_W = 4;

  typedef enum logic [0:0] {
    SWP_IDLE = 1'b0,
    SWP_RUN  = 1'b1
  } sweep_state_t;
endpackage

// File: rtl/vtbt_version.sv
module vtbt_version #(
  parameter int VER_W = vtbt_pkg::VER_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dom_switch,
  output logic [VER_W-1:0] cur_ver,
  output logic [VER_W-1:0] next_ver,
  output logic             wrap
);
  localparam logic [VER_W-1:0] VER_MAX = '1;
  localparam logic [VER_W-1:0] VER_ONE = VER_W'(1);

  logic [VER_W-1:0] ver_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ver_q <= '0;
    end else if (dom_switch) begin
      ver_q <= ver_q + VER_ONE;
    end
  end

  assign cur_ver  = ver_q;
  assign next_ver = dom_switch ? (ver_q + VER_ONE) : ver_q;
  assign wrap     = dom_switch && (ver_q == VER_MAX);
endmodule

// File: rtl/vtbt_sweep.sv
module vtbt_sweep #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             clr_en,
  output logic [IDX_W-1:0] clr_idx
);
  import vtbt_pkg::*;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  sweep_state_t     st_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SWP_IDLE;
      idx_q <= '0;
    end else if (start) begin
      st_q  <= SWP_RUN;
      idx_q <= '0;
    end else if (st_q == SWP_RUN) begin
      if (idx_q == LAST) begin
        st_q  <= SWP_IDLE;
        idx_q <= '0;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  assign busy    = (st_q == SWP_RUN);
  assign clr_en  = busy;
  assign clr_idx = idx_q;
endmodule

// File: rtl/vtbt_store.sv
module vtbt_store #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 26,
  parameter int TGT_W = 32,
  parameter int VER_W = vtbt_pkg::VER_W,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [TAG_W-1:0] wtag,
  input  logic [TGT_W-1:0] wtgt,
  input  logic [VER_W-1:0] wver,
  input  logic             ce,
  input  logic [IDX_W-1:0] cidx,
  input  logic [IDX_W-1:0] ridx,
  output logic             rvalid,
  output logic [TAG_W-1:0] rtag,
  output logic [TGT_W-1:0] rtgt,
  output logic [VER_W-1:0] rver
);
  logic [DEPTH-1:0] valid_vec;
  logic [TAG_W-1:0] tag_arr [DEPTH];
  logic [TGT_W-1:0] tgt_arr [DEPTH];
  logic [VER_W-1:0] ver_arr [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    logic             row_valid;
    logic [TAG_W-1:0] row_tag;
    logic [TGT_W-1:0] row_tgt;
    logic [VER_W-1:0] row_ver;
    logic             row_wr;
    logic             row_clr;

    assign row_wr  = we && (widx == IDX_W'(i));
    assign row_clr = ce && (cidx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        row_valid <= 1'b0;
      end else if (row_clr) begin
        row_valid <= 1'b0;
      end else if (row_wr) begin
        row_valid <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (row_wr) begin
        row_tag <= wtag;
        row_tgt <= wtgt;
        row_ver <= wver;
      end
    end

    assign valid_vec[i] = row_valid;
    assign tag_arr[i]   = row_tag;
    assign tgt_arr[i]   = row_tgt;
    assign ver_arr[i]   = row_ver;
  end

  assign rvalid = valid_vec[ridx];
  assign rtag   = tag_arr[ridx];
  assign rtgt   = tgt_arr[ridx];
  assign rver   = ver_arr[ridx];
endmodule

// File: rtl/vtbt_table.sv
module vtbt_table #(
  parameter int PC_W  = 32,
  parameter int TGT_W = 32,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             lk_hit,
  output logic [TGT_W-1:0] lk_target,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [PC_W-1:0]  up_pc,
  input  logic [TGT_W-1:0] up_target,
  input  logic             dom_switch,
  output logic             busy
);
  localparam int VER_W = vtbt_pkg::VER_W;
  localparam int OFS_W = 2;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int TAG_W = PC_W - IDX_W - OFS_W;

  logic [VER_W-1:0] cur_ver;
  logic [VER_W-1:0] next_ver;
  logic             wrap;
  logic             clr_en;
  logic [IDX_W-1:0] clr_idx;
  logic             up_fire;
  logic             rd_valid;
  logic [TAG_W-1:0] rd_tag;
  logic [TGT_W-1:0] rd_tgt;
  logic [VER_W-1:0] rd_ver;
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic [IDX_W-1:0] up_idx;
  logic [TAG_W-1:0] up_tag;

  assign lk_idx = lk_pc[OFS_W +: IDX_W];
  assign lk_tag = lk_pc[PC_W-1 -: TAG_W];
  assign up_idx = up_pc[OFS_W +: IDX_W];
  assign up_tag = up_pc[PC_W-1 -: TAG_W];

  vtbt_version #(.VER_W(VER_W)) u_ver (
    .clk       (clk),
    .rst_n     (rst_n),
    .dom_switch(dom_switch),
    .cur_ver   (cur_ver),
    .next_ver  (next_ver),
    .wrap      (wrap)
  );

  vtbt_sweep #(.DEPTH(DEPTH)) u_sweep (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (wrap),
    .busy   (busy),
    .clr_en (clr_en),
    .clr_idx(clr_idx)
  );

  assign up_ready = !busy && !wrap;
  assign up_fire  = up_valid && up_ready;

  vtbt_store #(
    .DEPTH(DEPTH),
    .TAG_W(TAG_W),
    .TGT_W(TGT_W),
    .VER_W(VER_W)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (up_fire),
    .widx  (up_idx),
    .wtag  (up_tag),
    .wtgt  (up_target),
    .wver  (next_ver),
    .ce    (clr_en),
    .cidx  (clr_idx),
    .ridx  (lk_idx),
    .rvalid(rd_valid),
    .rtag  (rd_tag),
    .rtgt  (rd_tgt),
    .rver  (rd_ver)
  );

  assign lk_hit    = lk_valid && !busy && rd_valid &&
                     (rd_tag == lk_tag) && (rd_ver == cur_ver);
  assign lk_target = rd_tgt;
endmodule

// File: rtl/vtbt_table_chk.sv
module vtbt_table_chk #(
  parameter int DEPTH = 16,
  parameter int VER_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dom_switch,
  input logic             up_valid,
  input logic             up_ready,
  input logic             lk_valid,
  input logic             lk_hit,
  input logic             busy,
  input logic [VER_W-1:0] cur_ver
);
  localparam int CNT_W = $clog2(DEPTH) + 2;
  localparam logic [VER_W-1:0] VER_MAX = '1;

  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) run_cnt <= '0;
    else                 run_cnt <= run_cnt + CNT_W'(1);
  end

  AST_VER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dom_switch |=> cur_ver == VER_W'($past(cur_ver) + VER_W'(1))); // R2
  AST_SWITCH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_switch && !(up_valid && up_ready)) |=> !lk_hit); // R3
  AST_WRAP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_switch && cur_ver == VER_MAX) |=> busy); // R7
  AST_SWEEP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_cnt == CNT_W'(DEPTH)); // R7
  AST_BUSY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !lk_hit); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !up_ready); // R9
  AST_WRAP_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_switch && cur_ver == VER_MAX) |-> !up_ready); // R10
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_hit); // R11
endmodule

bind vtbt_table vtbt_table_chk #(
  .DEPTH(DEPTH),
  .VER_W(vtbt_pkg::VER_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dom_switch(dom_switch),
  .up_valid  (up_valid),
  .up_ready  (up_ready),
  .lk_valid  (lk_valid),
  .lk_hit    (lk_hit),
  .busy      (busy),
  .cur_ver   (cur_ver)
);

// File: tb/vtbt_table_test.sv
module vtbt_table_test;
  localparam int PC_W  = 32;
  localparam int TGT_W = 32;
  localparam int DEPTH = 16;
  localparam int NVEC  = 12;

  typedef struct packed {
    logic [1:0]       op;   // bit0 update, bit1 switch
    logic [PC_W-1:0]  upc;
    logic [TGT_W-1:0] utgt;
    logic [PC_W-1:0]  qpc;
    logic             ehit;
    logic [TGT_W-1:0] etgt;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{2'b01, 32'h100, 32'hA00, 32'h100, 1'b1, 32'hA00}, // R5
    '{2'b00, 32'h0,   32'h0,   32'h200, 1'b0, 32'h0},   // R4 tag differs
    '{2'b01, 32'h104, 32'hB04, 32'h104, 1'b1, 32'hB04}, // R5
    '{2'b00, 32'h0,   32'h0,   32'h100, 1'b1, 32'hA00}, // R4
    '{2'b10, 32'h0,   32'h0,   32'h100, 1'b0, 32'h0},   // R3
    '{2'b00, 32'h0,   32'h0,   32'h104, 1'b0, 32'h0},   // R3
    '{2'b11, 32'h108, 32'hC08, 32'h108, 1'b1, 32'hC08}, // R6
    '{2'b01, 32'h100, 32'hD00, 32'h100, 1'b1, 32'hD00}, // R5
    '{2'b10, 32'h0,   32'h0,   32'h100, 1'b0, 32'h0},   // R3
    '{2'b01, 32'h200, 32'hE00, 32'h200, 1'b1, 32'hE00}, // R5
    '{2'b01, 32'h100, 32'hF00, 32'h200, 1'b0, 32'h0},   // R5 same index
    '{2'b00, 32'h0,   32'h0,   32'h100, 1'b1, 32'hF00}  // R4
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             lk_valid = 1'b0;
  logic [PC_W-1:0]  lk_pc = '0;
  logic             lk_hit;
  logic [TGT_W-1:0] lk_target;
  logic             up_valid = 1'b0;
  logic             up_ready;
  logic [PC_W-1:0]  up_pc = '0;
  logic [TGT_W-1:0] up_target = '0;
  logic             dom_switch = 1'b0;
  logic             busy;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  vtbt_table #(.PC_W(PC_W), .TGT_W(TGT_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_target(lk_target),
    .up_valid(up_valid), .up_ready(up_ready), .up_pc(up_pc), .up_target(up_target),
    .dom_switch(dom_switch), .busy(busy)
  );

  task automatic chk(input string req, input logic [TGT_W-1:0] act, input logic [TGT_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic query(input string req, input logic [PC_W-1:0] pc,
                       input logic ehit, input logic [TGT_W-1:0] etgt);
    lk_valid = 1'b1;
    lk_pc    = pc;
    #2;
    chk({req, " hit"}, TGT_W'(lk_hit), TGT_W'(ehit));
    if (ehit) chk({req, " target"}, lk_target, etgt);
  endtask

  task automatic act(input logic upd, input logic sw,
                     input logic [PC_W-1:0] pc, input logic [TGT_W-1:0] tgt);
    @(negedge clk);
    lk_valid = 1'b0; up_valid = upd; dom_switch = sw; up_pc = pc; up_target = tgt;
    @(negedge clk);
    up_valid = 1'b0; dom_switch = 1'b0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", TGT_W'(busy), 0);
    chk("R1 up_ready", TGT_W'(up_ready), 1);
    query("R1 empty", 32'h100, 1'b0, '0);

    for (int i = 0; i < NVEC; i++) begin
      act(VEC[i].op[0], VEC[i].op[1], VEC[i].upc, VEC[i].utgt);
      query($sformatf("vec%0d R4/R5/R3/R6", i), VEC[i].qpc, VEC[i].ehit, VEC[i].etgt);
    end

    // R11 idle lookup of a live entry
    lk_valid = 1'b0; lk_pc = 32'h100; #2;
    chk("R11 no request", TGT_W'(lk_hit), 0);

    // version is 3; step to 15
    for (int k = 0; k < 12; k++) act(1'b0, 1'b1, '0, '0);
    act(1'b1, 1'b0, 32'h140, 32'h1234);
    query("R2 twelve switches then write", 32'h140, 1'b1, 32'h1234);

    // wrapping switch with an update offered
    @(negedge clk);
    lk_valid = 1'b0; dom_switch = 1'b1; up_valid = 1'b1; up_pc = 32'h144; up_target = 32'h99;
    #2;
    chk("R10 ready low on wrap", TGT_W'(up_ready), 0);
    chk("R10 busy still low", TGT_W'(busy), 0);
    @(negedge clk);
    dom_switch = 1'b0; up_pc = 32'h10C; up_target = 32'h777;
    #2;
    chk("R7 busy after wrap", TGT_W'(busy), 1);
    chk("R9 ready low while busy", TGT_W'(up_ready), 0);
    query("R9 miss while busy", 32'h10C, 1'b0, '0);
    cnt = 1;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk); #2;
      if (!busy) break;
      cnt++;
    end
    up_valid = 1'b0;
    chk("R7 sweep length", TGT_W'(cnt), TGT_W'(DEPTH));
    query("R9 dropped update", 32'h10C, 1'b0, '0);
    query("R10 dropped wrap update", 32'h144, 1'b0, '0);
    query("R8 ver0 row swept", 32'h104, 1'b0, '0);
    act(1'b0, 1'b1, '0, '0);
    act(1'b0, 1'b1, '0, '0);
    query("R8 ver2 row swept", 32'h108, 1'b0, '0);
    act(1'b1, 1'b0, 32'h104, 32'h5555);
    query("R5 write after sweep", 32'h104, 1'b1, 32'h5555);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule